// File: doc/BRIEF.md
# Dual Display List Sequencer

This block walks two independent display lists during the horizontal blanking interval of every visible scanline. A display list is a run of 32-bit instructions. Each instruction either stores a 16-bit value into one entry of a small file of video control registers, or holds the list until the raster reaches a given physical line. The control registers hold values such as framebuffer address halves, pitch, scroll, mode and palette entries. They sit outside this block and are fed from its write port.

Each list has its own program counter and its own synchronous read port with one cycle of latency. On a frame strobe both counters are reloaded from per-list start addresses. On each hblank start strobe for a visible line, the sequencer takes one instruction from each list in turn until both lists are parked on a wait that is not yet satisfied. It then raises `done`. If blanking ends first, the sequencer stops where it is and flags an overrun. It continues from the same place on the next line.

Top module: `dual_list_sequencer`

## Requirements
- R1: An instruction word carries the register offset in bits [31:16] and the parameter in bits [15:0]. A nonzero offset below NREGS (32) produces exactly one write-port write of the parameter to that offset, one cycle after the instruction executes, and the list moves to its next word.
- R2: Offset zero is a wait. If `line_num` is greater than or equal to the parameter, the wait passes and the same list carries on within the same blanking interval.
- R3: A wait that is not satisfied leaves that list's counter on the wait. The wait is tested again on the next visible line.
- R4: `done` goes high once both lists are parked on unsatisfied waits. It stays high until the next accepted hblank start or frame start, and it is never high while either list can still run.
- R5: Within one line the lists are serviced alternately, one instruction at a time, starting with list 0. When one list is parked, the other keeps running alone. At most one read port is active in any cycle.
- R6: `frame_start` reloads list 0 from `start_addr0` and list 1 from `start_addr1`, clears `done` and `overrun`, and leaves both lists idle until the next hblank start.
- R7: An hblank start with `line_num` at or above 768 is ignored, so no read and no write follows it. A wait parameter of 0xFFF is never satisfied, which ends a list for the rest of the frame.
- R8: If `hblank_active` drops before both lists are parked, `overrun` is set and the sequencer stops. `overrun` stays set until the next accepted hblank start. No pending store is lost or repeated: the next line continues from the interrupted instruction.
- R9: A store whose offset is NREGS or above produces no write. It sets `store_err`, which stays high until reset.
- R10: After reset, `done`, `overrun`, `store_err`, `wr_en` and both read enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame strobe; reloads both list counters |
| hblank_start | input | 1 | Strobe at the start of horizontal blanking |
| hblank_active | input | 1 | High for the whole blanking interval |
| line_num | input | LINE_W | Current physical raster line |
| start_addr0 | input | AW | Start word address of list 0 |
| start_addr1 | input | AW | Start word address of list 1 |
| l0_rd_en | output | 1 | Read enable, list 0 memory |
| l0_rd_addr | output | AW | Read word address, list 0 memory |
| l0_rd_data | input | 32 | Read data, list 0 memory, one cycle after enable |
| l1_rd_en | output | 1 | Read enable, list 1 memory |
| l1_rd_addr | output | AW | Read word address, list 1 memory |
| l1_rd_data | input | 32 | Read data, list 1 memory, one cycle after enable |
| wr_en | output | 1 | Control register write strobe |
| wr_addr | output | RA_W | Control register offset |
| wr_data | output | 16 | Control register value |
| done | output | 1 | Both lists parked for this line |
| overrun | output | 1 | Blanking ended before both lists parked |
| store_err | output | 1 | Sticky out-of-range store flag |

## Verification
The hardest state to reach is an overrun that lands in the middle of a list. Blanking has to close while a fetch or an execute is in flight, and the resumed line must then issue exactly the stores that were still missing. The bench reaches this with a blanking window of a few cycles against a long run of stores, then counts every write across the cut and the following full line. The other directed cases are the alternation order, a wait at exactly its line and one line before it, hblank starts on lines past the visible area, and an out-of-range offset. Random frames of stores and rising waits then run at random line steps against a bench model of the lists.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_EXEC  = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic [15:0] off;
    logic [15:0] arg;
  } dl_word_t;

  // A wait passes once the raster has reached its target line.
  function automatic logic wait_passed(input logic [15:0] cur_line,
                                       input logic [15:0] target);
    return cur_line >= target;
  endfunction

  // Alternation: prefer the other list, fall back to the current one.
  // Returns {more_work, next_sel}.
  function automatic logic [1:0] pick_next(input logic       cur,
                                           input logic [1:0] blk);
    logic other;
    other = ~cur;
    if (!blk[other])    return {1'b1, other};
    else if (!blk[cur]) return {1'b1, cur};
    else                return {1'b0, cur};
  endfunction

endpackage

// File: rtl/dls_list_ctx.sv
module dls_list_ctx #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [AW-1:0] start_addr,
  input  logic          line_go,
  input  logic          advance,
  input  logic          block,
  output logic [AW-1:0] pc,
  output logic          blocked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= '0;
      blocked <= 1'b1;
    end else if (reload) begin
      pc      <= start_addr;
      blocked <= 1'b1;
    end else begin
      if (line_go)    blocked <= 1'b0;
      else if (block) blocked <= 1'b1;
      if (advance)    pc <= pc + 1'b1;
    end
  end

  // R3: a parked list keeps its counter until a new line or frame
  a_r3_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !reload && !line_go) |=> $stable(pc));

endmodule

// File: rtl/dls_decode.sv
module dls_decode
  import dls_pkg::*;
#(
  parameter int NREGS  = 32,
  parameter int LINE_W = 11
) (
  input  logic [31:0]       word,
  input  logic [LINE_W-1:0] line_num,
  output logic              is_wait,
  output logic              wait_ok,
  output logic              off_ok,
  output logic [15:0]       off,
  output logic [15:0]       arg
);

  dl_word_t    w;
  logic [15:0] cur16;

  always_comb begin
    w       = dl_word_t'(word);
    off     = w.off;
    arg     = w.arg;
    cur16   = 16'(line_num);
    is_wait = (w.off == 16'd0);
    wait_ok = wait_passed(cur16, w.arg);
    off_ok  = (32'(w.off) < NREGS);
  end

endmodule

// File: rtl/dls_arbiter.sv
module dls_arbiter
  import dls_pkg::*;
(
  input  logic       cur,
  input  logic [1:0] blk_after,
  output logic       more,
  output logic       nxt
);

  logic [1:0] choice;

  always_comb begin
    choice = pick_next(cur, blk_after);
    more   = choice[1];
    nxt    = choice[0];
  end

endmodule

// File: rtl/dual_list_sequencer.sv
module dual_list_sequencer
  import dls_pkg::*;
#(
  parameter int AW        = 8,
  parameter int NREGS     = 32,
  parameter int LINE_W    = 11,
  parameter int VIS_LINES = 768,
  localparam int RA_W     = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              hblank_start,
  input  logic              hblank_active,
  input  logic [LINE_W-1:0] line_num,
  input  logic [AW-1:0]     start_addr0,
  input  logic [AW-1:0]     start_addr1,
  output logic              l0_rd_en,
  output logic [AW-1:0]     l0_rd_addr,
  input  logic [31:0]       l0_rd_data,
  output logic              l1_rd_en,
  output logic [AW-1:0]     l1_rd_addr,
  input  logic [31:0]       l1_rd_data,
  output logic              wr_en,
  output logic [RA_W-1:0]   wr_addr,
  output logic [15:0]       wr_data,
  output logic              done,
  output logic              overrun,
  output logic              store_err
);

  localparam int NLISTS = 2;

  seq_state_t  state;
  logic        sel;
  logic [1:0]  blocked;
  logic [AW-1:0] pc     [NLISTS];
  logic [AW-1:0] starts [NLISTS];
  logic [1:0]  advance, block;

  // Named events for the assertions and the sequencer
  logic        line_ok, line_go, exec_go, abort_now, step_blk;
  logic [1:0]  blk_after;
  logic        more, nxt;

  logic [31:0] word;
  logic        is_wait, wait_ok, off_ok;
  logic [15:0] off, arg;

  assign starts[0] = start_addr0;
  assign starts[1] = start_addr1;

  assign word      = sel ? l1_rd_data : l0_rd_data;
  assign line_ok   = (32'(line_num) < VIS_LINES);
  assign line_go   = hblank_start && line_ok && !frame_start;
  assign exec_go   = (state == SQ_EXEC) && hblank_active && !frame_start && !line_go;
  assign abort_now = (state != SQ_IDLE) && !hblank_active && !frame_start && !line_go;
  assign step_blk  = exec_go && is_wait && !wait_ok;
  assign blk_after = blocked | (step_blk ? (2'b01 << sel) : 2'b00);

  dls_decode #(.NREGS(NREGS), .LINE_W(LINE_W)) u_decode (
    .word     (word),
    .line_num (line_num),
    .is_wait  (is_wait),
    .wait_ok  (wait_ok),
    .off_ok   (off_ok),
    .off      (off),
    .arg      (arg)
  );

  dls_arbiter u_arb (
    .cur       (sel),
    .blk_after (blk_after),
    .more      (more),
    .nxt       (nxt)
  );

  always_comb begin
    for (int i = 0; i < NLISTS; i++) begin
      advance[i] = exec_go && (sel == 1'(i)) && !(is_wait && !wait_ok);
      block[i]   = step_blk && (sel == 1'(i));
    end
  end

  for (genvar g = 0; g < NLISTS; g++) begin : g_list
    dls_list_ctx #(.AW(AW)) u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload     (frame_start),
      .start_addr (starts[g]),
      .line_go    (line_go),
      .advance    (advance[g]),
      .block      (block[g]),
      .pc         (pc[g]),
      .blocked    (blocked[g])
    );
  end

  assign l0_rd_en   = (state == SQ_FETCH) && hblank_active && !sel;
  assign l1_rd_en   = (state == SQ_FETCH) && hblank_active && sel;
  assign l0_rd_addr = pc[0];
  assign l1_rd_addr = pc[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      sel       <= 1'b0;
      done      <= 1'b0;
      overrun   <= 1'b0;
      store_err <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en   <= exec_go && !is_wait && off_ok;
      wr_addr <= off[RA_W-1:0];
      wr_data <= arg;
      if (exec_go && !is_wait && !off_ok) store_err <= 1'b1;

      if (frame_start) begin
        state   <= SQ_IDLE;
        sel     <= 1'b0;
        done    <= 1'b0;
        overrun <= 1'b0;
      end else if (line_go) begin
        state   <= SQ_FETCH;
        sel     <= 1'b0;
        done    <= 1'b0;
        overrun <= 1'b0;
      end else if (abort_now) begin
        state   <= SQ_IDLE;
        overrun <= 1'b1;
      end else begin
        unique case (state)
          SQ_FETCH: state <= SQ_EXEC;
          SQ_EXEC: begin
            if (more) begin
              sel   <= nxt;
              state <= SQ_FETCH;
            end else begin
              state <= SQ_IDLE;
              done  <= 1'b1;
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end

  // R1: offset zero is the wait code and never reaches the write port
  a_r1_wr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr != '0));

  // R4: done only while both lists are parked
  a_r4_done_parked: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&blocked));

  // R5: one instruction fetch at a time
  a_r5_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({l0_rd_en, l1_rd_en}));

  // R7: hblank past the visible area starts nothing
  a_r7_offscreen_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank_start && !line_ok && !frame_start && state == SQ_IDLE)
      |=> (!l0_rd_en && !l1_rd_en));

  // R8: blanking closing mid-list raises overrun and stops the sequencer
  a_r8_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SQ_IDLE && !hblank_active && !frame_start && !hblank_start)
      |=> (overrun && !l0_rd_en && !l1_rd_en));

  // R9: error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    store_err |=> store_err);

endmodule

// File: tb/dual_list_sequencer_test.sv
module dual_list_sequencer_test;

  localparam int AW = 8;
  localparam int NREGS = 32;
  localparam int LINE_W = 11;
  localparam int RA_W = $clog2(NREGS);
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, hblank_start = 1'b0, hblank_active = 1'b0;
  logic [LINE_W-1:0] line_num = '0;
  logic [AW-1:0] start_addr0 = '0, start_addr1 = '0;
  logic l0_rd_en, l1_rd_en;
  logic [AW-1:0] l0_rd_addr, l1_rd_addr;
  logic [31:0] l0_rd_data = '0, l1_rd_data = '0;
  logic wr_en;
  logic [RA_W-1:0] wr_addr;
  logic [15:0] wr_data;
  logic done, overrun, store_err;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dual_list_sequencer #(.AW(AW), .NREGS(NREGS), .LINE_W(LINE_W)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .hblank_start(hblank_start), .hblank_active(hblank_active),
    .line_num(line_num), .start_addr0(start_addr0), .start_addr1(start_addr1),
    .l0_rd_en(l0_rd_en), .l0_rd_addr(l0_rd_addr), .l0_rd_data(l0_rd_data),
    .l1_rd_en(l1_rd_en), .l1_rd_addr(l1_rd_addr), .l1_rd_data(l1_rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .overrun(overrun), .store_err(store_err)
  );

  // List memories: one cycle read latency
  logic [31:0] mem0 [DEPTH];
  logic [31:0] mem1 [DEPTH];
  always @(posedge clk) begin
    if (l0_rd_en) l0_rd_data <= mem0[l0_rd_addr];
    if (l1_rd_en) l1_rd_data <= mem1[l1_rd_addr];
  end

  // Observed register file and write log
  logic [15:0] cap [NREGS];
  logic [RA_W-1:0] wlog [256];
  int wcount = 0;
  initial for (int r = 0; r < NREGS; r++) cap[r] = '0;
  always @(posedge clk) begin
    if (rst_n && wr_en) begin
      cap[wr_addr] <= wr_data;
      wlog[wcount % 256] <= wr_addr;
      wcount <= wcount + 1;
    end
  end

  // Bench model state
  logic [15:0] exp_regs [NREGS];
  int ref_pc [2];
  bit exp_err = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    checks++;
    fails++;
    $display("FAIL R4 watchdog expired: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  task automatic clear_mems();
    for (int a = 0; a < DEPTH; a++) begin
      mem0[a] = {16'h0000, 16'h0FFF};
      mem1[a] = {16'h0000, 16'h0FFF};
    end
  endtask

  task automatic put(input int lst, input int addr, input logic [15:0] off,
                     input logic [15:0] arg);
    if (lst == 0) mem0[addr] = {off, arg};
    else          mem1[addr] = {off, arg};
  endtask

  task automatic new_frame(input int s0, input int s1);
    @(negedge clk);
    start_addr0 = AW'(s0);
    start_addr1 = AW'(s1);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    ref_pc[0] = s0;
    ref_pc[1] = s1;
  endtask

  task automatic run_line(input int ln, input int hb);
    @(negedge clk);
    line_num = LINE_W'(ln);
    hblank_start = 1'b1;
    hblank_active = 1'b1;
    @(negedge clk);
    hblank_start = 1'b0;
    repeat (hb) @(negedge clk);
    hblank_active = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Bench restatement of one line of list execution
  task automatic ref_line(input int ln);
    for (int l = 0; l < 2; l++) begin
      for (int k = 0; k < 400; k++) begin
        logic [31:0] w;
        w = (l == 0) ? mem0[ref_pc[l] % DEPTH] : mem1[ref_pc[l] % DEPTH];
        if (w[31:16] == 16'd0) begin
          if (ln >= int'(w[15:0])) ref_pc[l]++;
          else break;
        end else begin
          if (int'(w[31:16]) < NREGS) exp_regs[w[31:16]] = w[15:0];
          else exp_err = 1'b1;
          ref_pc[l]++;
        end
      end
    end
  endtask

  task automatic gen_prog(input int lst, input int start, input int base,
                          input int span, input int first_line);
    int a = start;
    int wl = first_line;
    for (int k = 0; k < 22; k++) begin
      int pick = $urandom % 100;
      if (pick < 55) begin
        put(lst, a, 16'(base + ($urandom % span)), 16'($urandom));
      end else if (pick < 60) begin
        put(lst, a, 16'(NREGS + ($urandom % 200)), 16'($urandom));
      end else begin
        wl += $urandom % 40;
        put(lst, a, 16'd0, 16'(wl));
      end
      a++;
    end
    put(lst, a, 16'd0, 16'h0FFF);
  endtask

  task automatic cmp_regs(input string req, input int ln);
    int bad = -1;
    for (int r = 1; r < NREGS; r++)
      if (cap[r] !== exp_regs[r] && bad < 0) bad = r;
    chk(bad < 0, req, $sformatf("register file after line %0d (reg %0d)", ln, bad),
        (bad < 0) ? 0 : int'(cap[bad]), (bad < 0) ? 0 : int'(exp_regs[bad]));
  endtask

  initial begin
    int w0;
    void'($urandom(32'd20250));
    clear_mems();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!done && !overrun && !store_err, "R10", "flags after reset",
        int'({done, overrun, store_err}), 0);
    chk(!wr_en && !l0_rd_en && !l1_rd_en, "R10", "strobes after reset",
        int'({wr_en, l0_rd_en, l1_rd_en}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 alternation order
    clear_mems();
    put(0, 0, 16'd1, 16'h00A1);
    put(0, 1, 16'd2, 16'h00A2);
    put(0, 2, 16'd3, 16'h00A3);
    put(1, 128, 16'd16, 16'h00B0);
    put(1, 129, 16'd17, 16'h00B1);
    new_frame(0, 128);
    w0 = wcount;
    run_line(10, 120);
    chk(wcount - w0 == 5, "R5", "write count, alternation", wcount - w0, 5);
    chk(wlog[(w0 + 0) % 256] == 1 && wlog[(w0 + 1) % 256] == 16 &&
        wlog[(w0 + 2) % 256] == 2 && wlog[(w0 + 3) % 256] == 17 &&
        wlog[(w0 + 4) % 256] == 3, "R5", "write order 1,16,2,17,3",
        int'(wlog[(w0 + 1) % 256]), 16);
    chk(cap[3] == 16'h00A3 && cap[17] == 16'h00B1, "R1", "stored values",
        int'(cap[3]), 'hA3);
    chk(done == 1'b1, "R4", "done after both lists parked", int'(done), 1);

    // R6 reload and R7 off-screen / terminator
    new_frame(0, 128);
    chk(done == 1'b0, "R6", "frame start clears done", int'(done), 0);
    w0 = wcount;
    run_line(768, 60);
    chk(wcount == w0, "R7", "no writes on line 768", wcount - w0, 0);
    run_line(767, 120);
    chk(wcount - w0 == 5, "R6", "lists restart from start addresses", wcount - w0, 5);
    w0 = wcount;
    run_line(767, 120);
    chk(wcount == w0, "R7", "0xFFF wait never passes", wcount - w0, 0);
    chk(done == 1'b1, "R4", "done with both lists terminated", int'(done), 1);

    // R2 / R3 wait boundary
    clear_mems();
    put(0, 0, 16'd0, 16'd100);
    put(0, 1, 16'd5, 16'h0055);
    new_frame(0, 0);
    w0 = wcount;
    run_line(99, 60);
    chk(wcount == w0, "R3", "wait 100 on line 99 holds", wcount - w0, 0);
    chk(done == 1'b1, "R4", "done with list 0 parked on wait", int'(done), 1);
    run_line(100, 60);
    chk(wcount - w0 == 1 && cap[5] == 16'h0055, "R2", "wait 100 passes on line 100",
        int'(cap[5]), 'h55);

    // R8 overrun and resume
    clear_mems();
    for (int k = 0; k < 12; k++) put(0, k, 16'(k + 1), 16'(16'h0300 + k));
    new_frame(0, 0);
    w0 = wcount;
    run_line(20, 6);
    chk(overrun == 1'b1, "R8", "overrun after short blanking", int'(overrun), 1);
    chk(done == 1'b0, "R8", "done low after overrun", int'(done), 0);
    chk(wcount - w0 > 0 && wcount - w0 < 12, "R8", "partial stores in short blanking",
        wcount - w0, 3);
    repeat (5) @(negedge clk);
    chk(overrun == 1'b1, "R8", "overrun held until next line", int'(overrun), 1);
    run_line(21, 120);
    chk(overrun == 1'b0, "R8", "overrun cleared by next hblank", int'(overrun), 0);
    chk(wcount - w0 == 12, "R8", "no store lost or repeated", wcount - w0, 12);
    chk(cap[12] == 16'h030B && cap[1] == 16'h0300, "R8", "resumed values",
        int'(cap[12]), 'h30B);

    // Random frames checked against the bench model
    chk(store_err == 1'b0, "R9", "no error before bad offsets", int'(store_err), 0);
    for (int f = 0; f < 4; f++) begin
      int s0 = $urandom % 64;
      int s1 = 128 + ($urandom % 64);
      int ln = $urandom % 5;
      clear_mems();
      gen_prog(0, s0, 1, 15, ln);
      gen_prog(1, s1, 16, 16, ln);
      new_frame(s0, s1);
      for (int r = 0; r < NREGS; r++) exp_regs[r] = cap[r];
      for (int n = 0; n < 40 && ln < 768; n++) begin
        run_line(ln, 120);
        ref_line(ln);
        cmp_regs("R1 R2 R3", ln);
        chk(done == 1'b1 && overrun == 1'b0, "R4", "done without overrun",
            int'({done, overrun}), 2);
        ln += 1 + ($urandom % 25);
      end
      chk(store_err == exp_err, "R9", "error flag after random frame",
          int'(store_err), int'(exp_err));
    end

    // R9 dropped store, sticky flag
    clear_mems();
    put(0, 0, 16'd40, 16'h1234);
    put(1, 0, 16'd0, 16'd0);
    put(1, 1, 16'd34, 16'h5678);
    new_frame(0, 0);
    w0 = wcount;
    run_line(3, 60);
    chk(wcount == w0, "R9", "out-of-range stores dropped", wcount - w0, 0);
    chk(store_err == 1'b1, "R9", "error flag set", int'(store_err), 1);
    new_frame(0, 0);
    chk(store_err == 1'b1, "R9", "error flag survives frame start", int'(store_err), 1);

    finish_run();
  end

endmodule